// File: doc/BRIEF.md
# GNSS correlator packet framer

The framer gathers the latest in-phase (I) and quadrature (Q) correlation words and an 8-bit time value from each of twelve tracking channels. At a regular interval it sends them downstream as one fixed-length byte packet. Two control inputs set the interval. One picks tracking or acquisition mode. The other picks one of two packet rates within that mode. Every packet starts with a sync byte and a tag byte. In tracking mode the tag carries the low bits of the current time count. In acquisition mode the tag either marks the first packet of a satellite millisecond or carries a sequence number that counts the packets after it.

At each interval tick the framer copies all channel inputs into a snapshot register. It sends the packet from that snapshot, one byte per accepted valid/ready handshake, and marks the final byte with a last flag. A channel whose valid flag is low has both of its 16-bit words replaced by a marker word. If an interval tick arrives while bytes of the previous packet are still waiting, that tick is dropped and a sticky overrun flag is set.

Top module: `gnss_pkt_framer`

## Requirements
- R1: Every packet is 2 + 5*NUM_CH bytes long (62 with twelve channels). `out_last` is high on the final byte only, and never without `out_valid`.
- R2: Byte 0 is the sync byte (parameter, default 0xC3). Byte 1 is the tag byte.
- R3: Bytes 2..25 carry the I words of channels 0..11 and bytes 26..49 carry the Q words of channels 0..11. Each word is sent high byte first. Bytes 50..61 carry the time bytes of channels 0..11.
- R4: When `ch_valid[k]` is 0 at packet start, both 16-bit words of channel k are sent as 0x8000. The time byte of channel k is sent unchanged.
- R5: In tracking mode (`trk_mode`=1), every tag is {2'b10, `time_now`}, with `time_now` sampled at packet start.
- R6: In acquisition mode, a first-kind tag {2'b10, `time_now`} is sent on the first packet after an `epoch_tick` pulse, after reset, or after a control change. Every other packet has tag {2'b00, seq}, and seq starts at 2.
- R7: The acquisition sequence number saturates at 32 when `rate_sel`=0 and at 16 when `rate_sel`=1.
- R8: Packets start every N*CLKS_PER_US clock cycles. N is 840 (`rate_sel`=0) or 970 (`rate_sel`=1) in tracking mode, and 31 (`rate_sel`=0) or 62 (`rate_sel`=1) in acquisition mode.
- R9: A change of `trk_mode` or `rate_sel` restarts the interval timer. The next packet starts one full new interval after the change, and its tag is of the first kind.
- R10: Channel input changes made while a packet is being sent do not alter that packet.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R12: `overrun` is 0 after reset. An interval tick that arrives while a byte of the current packet has not been accepted sets `overrun`, which then stays set until reset. That tick starts no packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trk_mode | input | 1 | 1 = tracking mode, 0 = acquisition mode |
| rate_sel | input | 1 | Selects one of the two intervals of the active mode |
| epoch_tick | input | 1 | One-cycle pulse at the start of a satellite millisecond |
| time_now | input | 6 | Low bits of the current time count |
| ch_valid | input | NUM_CH | Per-channel data-present flags |
| ch_i | input | 16*NUM_CH | Per-channel I words, channel 0 in the low bits |
| ch_q | input | 16*NUM_CH | Per-channel Q words, channel 0 in the low bits |
| ch_time | input | 8*NUM_CH | Per-channel time bytes, channel 0 in the low bits |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the packet |
| overrun | output | 1 | Sticky dropped-tick flag |

## Verification
The hardest situation to reach is sequence-number saturation. It needs a long run of back-to-back acquisition packets with no epoch pulse and no control change, so the bench keeps `out_ready` high and lets more than thirty packets pass in one millisecond window. A control change is then made in the middle of an interval, and the bench times the next packet start against the change cycle. Overrun is reached by holding `out_ready` low across more than one interval. The bench then checks that the packet already pending is still intact.

// File: rtl/gfr_pkg.sv
package gfr_pkg;
   localparam int WORD_W     = 16;
   localparam int TBYTE_W    = 8;
   localparam int TAGT_W     = 6;
   localparam int TRK_US_A   = 840;
   localparam int TRK_US_B   = 970;
   localparam int ACQ_US_A   = 31;
   localparam int ACQ_US_B   = 62;
   localparam int SEQ_START  = 2;
   localparam int SEQ_TOP_A  = 32;
   localparam int SEQ_TOP_B  = 16;
   localparam logic [1:0] TAG_KIND_FIRST = 2'b10;
   localparam logic [1:0] TAG_KIND_SEQ   = 2'b00;

   function automatic int pkt_len(input int nch);
      return 2 + 5 * nch;
   endfunction
endpackage

// File: rtl/gfr_interval_timer.sv
module gfr_interval_timer
   import gfr_pkg::*;
#(
   parameter int CLKS_PER_US = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trk_mode,
   input  logic rate_sel,
   output logic tick,
   output logic restart
);
   localparam int P_TA  = TRK_US_A * CLKS_PER_US;
   localparam int P_TB  = TRK_US_B * CLKS_PER_US;
   localparam int P_AA  = ACQ_US_A * CLKS_PER_US;
   localparam int P_AB  = ACQ_US_B * CLKS_PER_US;
   localparam int CNT_W = $clog2(P_TB + 1);

   if (CLKS_PER_US < 1) begin : g_bad_clk
      $error("CLKS_PER_US must be at least 1");
   end

   logic [1:0]       ctrl_q;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] period;

   always_comb begin
      unique case ({trk_mode, rate_sel})
         2'b10:   period = CNT_W'(P_TA);
         2'b11:   period = CNT_W'(P_TB);
         2'b00:   period = CNT_W'(P_AA);
         default: period = CNT_W'(P_AB);
      endcase
   end

   assign restart = (ctrl_q != {trk_mode, rate_sel});
   assign tick    = !restart && (cnt == period - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= 2'b00;
         cnt    <= '0;
      end else begin
         ctrl_q <= {trk_mode, rate_sel};
         if (restart || tick) cnt <= '0;
         else                 cnt <= cnt + CNT_W'(1);
      end
   end
endmodule

// File: rtl/gfr_tag_gen.sv
module gfr_tag_gen
   import gfr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              restart,
   input  logic              epoch_tick,
   input  logic              trk_mode,
   input  logic              rate_sel,
   input  logic [TAGT_W-1:0] time_now,
   output logic [7:0]        tag_next
);
   logic              first_pend;
   logic [TAGT_W-1:0] seq;
   logic [TAGT_W-1:0] seq_top;
   logic              is_first;

   assign seq_top  = rate_sel ? TAGT_W'(SEQ_TOP_B) : TAGT_W'(SEQ_TOP_A);
   assign is_first = trk_mode || first_pend || epoch_tick || restart;
   assign tag_next = is_first ? {TAG_KIND_FIRST, time_now} : {TAG_KIND_SEQ, seq};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_pend <= 1'b1;
         seq        <= TAGT_W'(SEQ_START);
      end else if (restart) begin
         first_pend <= 1'b1;
         seq        <= TAGT_W'(SEQ_START);
      end else if (start) begin
         first_pend <= 1'b0;
         if (is_first)            seq <= TAGT_W'(SEQ_START);
         else if (seq >= seq_top) seq <= seq_top;
         else                     seq <= seq + TAGT_W'(1);
      end else if (epoch_tick) begin
         first_pend <= 1'b1;
      end
   end
endmodule

// File: rtl/gfr_serializer.sv
module gfr_serializer
   import gfr_pkg::*;
#(
   parameter int          NUM_CH    = 12,
   parameter logic [7:0]  SYNC_BYTE = 8'hC3,
   parameter logic [15:0] PAD_WORD  = 16'h8000
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      tick,
   input  logic [7:0]                tag_next,
   input  logic [NUM_CH-1:0]         ch_valid,
   input  logic [NUM_CH*WORD_W-1:0]  ch_i,
   input  logic [NUM_CH*WORD_W-1:0]  ch_q,
   input  logic [NUM_CH*TBYTE_W-1:0] ch_time,
   input  logic                      out_ready,
   output logic                      start,
   output logic                      out_valid,
   output logic [7:0]                out_data,
   output logic                      out_last,
   output logic                      overrun
);
   localparam int I_BASE = 2;
   localparam int Q_BASE = I_BASE + 2 * NUM_CH;
   localparam int T_BASE = Q_BASE + 2 * NUM_CH;
   localparam int PKT    = pkt_len(NUM_CH);
   localparam int IDX_W  = $clog2(PKT);
   localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   logic [WORD_W-1:0]  pad_i  [NUM_CH];
   logic [WORD_W-1:0]  pad_q  [NUM_CH];
   logic [WORD_W-1:0]  snap_i [NUM_CH];
   logic [WORD_W-1:0]  snap_q [NUM_CH];
   logic [TBYTE_W-1:0] snap_t [NUM_CH];
   logic [7:0]         tag_q;
   logic               busy;
   logic [IDX_W-1:0]   idx;

   assign start = tick && !busy;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign pad_i[c] = ch_valid[c] ? ch_i[c*WORD_W +: WORD_W] : PAD_WORD;
      assign pad_q[c] = ch_valid[c] ? ch_q[c*WORD_W +: WORD_W] : PAD_WORD;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            snap_i[c] <= '0;
            snap_q[c] <= '0;
            snap_t[c] <= '0;
         end else if (start) begin
            snap_i[c] <= pad_i[c];
            snap_q[c] <= pad_q[c];
            snap_t[c] <= ch_time[c*TBYTE_W +: TBYTE_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         idx     <= '0;
         tag_q   <= '0;
         overrun <= 1'b0;
      end else begin
         if (tick && busy) overrun <= 1'b1;
         if (start) begin
            busy  <= 1'b1;
            idx   <= '0;
            tag_q <= tag_next;
         end else if (busy && out_ready) begin
            if (idx == IDX_W'(PKT - 1)) busy <= 1'b0;
            else                         idx  <= idx + IDX_W'(1);
         end
      end
   end

   logic [IDX_W-1:0]  off;
   logic [CH_W-1:0]   sel;
   logic [WORD_W-1:0] word;

   always_comb begin
      off      = '0;
      sel      = '0;
      word     = '0;
      out_data = SYNC_BYTE;
      if (idx == IDX_W'(1)) begin
         out_data = tag_q;
      end else if (idx >= IDX_W'(I_BASE) && idx < IDX_W'(Q_BASE)) begin
         off      = idx - IDX_W'(I_BASE);
         sel      = CH_W'(off >> 1);
         word     = snap_i[sel];
         out_data = off[0] ? word[7:0] : word[15:8];
      end else if (idx >= IDX_W'(Q_BASE) && idx < IDX_W'(T_BASE)) begin
         off      = idx - IDX_W'(Q_BASE);
         sel      = CH_W'(off >> 1);
         word     = snap_q[sel];
         out_data = off[0] ? word[7:0] : word[15:8];
      end else if (idx >= IDX_W'(T_BASE)) begin
         off      = idx - IDX_W'(T_BASE);
         sel      = CH_W'(off);
         out_data = snap_t[sel];
      end
   end

   assign out_valid = busy;
   assign out_last  = busy && (idx == IDX_W'(PKT - 1));
endmodule

// File: rtl/gnss_pkt_framer.sv
module gnss_pkt_framer
   import gfr_pkg::*;
#(
   parameter int          NUM_CH      = 12,
   parameter int          CLKS_PER_US = 4,
   parameter logic [7:0]  SYNC_BYTE   = 8'hC3,
   parameter logic [15:0] PAD_WORD    = 16'h8000
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      trk_mode,
   input  logic                      rate_sel,
   input  logic                      epoch_tick,
   input  logic [5:0]                time_now,
   input  logic [NUM_CH-1:0]         ch_valid,
   input  logic [NUM_CH*16-1:0]      ch_i,
   input  logic [NUM_CH*16-1:0]      ch_q,
   input  logic [NUM_CH*8-1:0]       ch_time,
   output logic                      out_valid,
   input  logic                      out_ready,
   output logic [7:0]                out_data,
   output logic                      out_last,
   output logic                      overrun
);
   localparam int PKT = pkt_len(NUM_CH);

   if (NUM_CH < 1) begin : g_bad_nch
      $error("NUM_CH must be at least 1");
   end
   if (ACQ_US_A * CLKS_PER_US <= PKT) begin : g_bad_rate
      $error("shortest interval must exceed the packet length in cycles");
   end

   logic       tick;
   logic       restart;
   logic       start;
   logic [7:0] tag_next;

   gfr_interval_timer #(.CLKS_PER_US(CLKS_PER_US)) u_timer (
      .clk(clk), .rst_n(rst_n), .trk_mode(trk_mode), .rate_sel(rate_sel),
      .tick(tick), .restart(restart)
   );

   gfr_tag_gen u_tag (
      .clk(clk), .rst_n(rst_n), .start(start), .restart(restart),
      .epoch_tick(epoch_tick), .trk_mode(trk_mode), .rate_sel(rate_sel),
      .time_now(time_now), .tag_next(tag_next)
   );

   gfr_serializer #(.NUM_CH(NUM_CH), .SYNC_BYTE(SYNC_BYTE), .PAD_WORD(PAD_WORD)) u_ser (
      .clk(clk), .rst_n(rst_n), .tick(tick), .tag_next(tag_next),
      .ch_valid(ch_valid), .ch_i(ch_i), .ch_q(ch_q), .ch_time(ch_time),
      .out_ready(out_ready), .start(start), .out_valid(out_valid),
      .out_data(out_data), .out_last(out_last), .overrun(overrun)
   );
endmodule

// File: rtl/gnss_pkt_framer_chk.sv
module gnss_pkt_framer_chk #(
   parameter int         PKT_BYTES = 62,
   parameter logic [7:0] SYNC_BYTE = 8'hC3
) (
   input logic       clk,
   input logic       rst_n,
   input logic       out_valid,
   input logic       out_ready,
   input logic [7:0] out_data,
   input logic       out_last,
   input logic       overrun
);
   localparam int BC_W = $clog2(PKT_BYTES);
   logic [BC_W-1:0] bcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bcnt <= '0;
      else if (out_valid && out_ready) bcnt <= out_last ? '0 : bcnt + BC_W'(1);
   end

   p_last_needs_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);
   p_last_position_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_last == (bcnt == BC_W'(PKT_BYTES - 1))));
   p_sync_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && bcnt == '0) |-> out_data == SYNC_BYTE);
   p_tag_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && bcnt == BC_W'(1)) |-> (out_data[6] == 1'b0));
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
   p_overrun_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);
endmodule

bind gnss_pkt_framer gnss_pkt_framer_chk #(
   .PKT_BYTES(2 + 5 * NUM_CH), .SYNC_BYTE(SYNC_BYTE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
   .out_data(out_data), .out_last(out_last), .overrun(overrun)
);

// File: tb/gnss_pkt_framer_bench.sv
module gnss_pkt_framer_bench;
   localparam int NCH = 12;
   localparam int CPU = 4;
   localparam int PKT = 2 + 5 * NCH;
   localparam logic [7:0] SYNC = 8'hC3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic trk_mode = 1'b1, rate_sel = 1'b0, epoch_tick = 1'b0, out_ready = 1'b1;
   logic [5:0] time_now = '0;
   logic [NCH-1:0] ch_valid = '1;
   logic [NCH*16-1:0] ch_i = '0, ch_q = '0;
   logic [NCH*8-1:0] ch_time = '0;
   logic out_valid, out_last, overrun;
   logic [7:0] out_data;

   gnss_pkt_framer #(.NUM_CH(NCH), .CLKS_PER_US(CPU)) u_gnss_pkt_framer (
      .clk(clk), .rst_n(rst_n), .trk_mode(trk_mode), .rate_sel(rate_sel),
      .epoch_tick(epoch_tick), .time_now(time_now), .ch_valid(ch_valid),
      .ch_i(ch_i), .ch_q(ch_q), .ch_time(ch_time), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
      .overrun(overrun)
   );

   always #4 clk = ~clk;

   int checks = 0, failures = 0, cyc = 0;
   logic [15:0] e_i [NCH];
   logic [15:0] e_q [NCH];
   logic [7:0]  e_t [NCH];
   logic [NCH-1:0] e_v;
   logic [7:0] got [PKT];
   int got_start;

   always @(posedge clk) cyc <= cyc + 1;

   always @(posedge clk) if (cyc > 150000) begin
      checks++; failures++;
      $display("FAIL R1 watchdog expired act=%0d exp<=150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s act=0x%0h exp=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic set_pattern(input int seed, input logic [NCH-1:0] v);
      for (int k = 0; k < NCH; k++) begin
         e_i[k] = 16'(seed * 4099 + k * 257 + 1);
         e_q[k] = 16'(seed * 7919 + k * 4369 + 3);
         e_t[k] = 8'(seed * 13 + k * 5);
         ch_i[k*16 +: 16] = e_i[k];
         ch_q[k*16 +: 16] = e_q[k];
         ch_time[k*8 +: 8] = e_t[k];
      end
      e_v = v;
      ch_valid = v;
   endtask

   function automatic logic [7:0] exp_byte(input int n, input logic [7:0] tag);
      logic [15:0] w;
      int k;
      if (n == 0) return SYNC;
      if (n == 1) return tag;
      if (n < 2 + 2 * NCH) begin
         k = (n - 2) / 2;
         w = e_v[k] ? e_i[k] : 16'h8000;
         return (n % 2 == 0) ? w[15:8] : w[7:0];
      end
      if (n < 2 + 4 * NCH) begin
         k = (n - 2 - 2 * NCH) / 2;
         w = e_v[k] ? e_q[k] : 16'h8000;
         return (n % 2 == 0) ? w[15:8] : w[7:0];
      end
      return e_t[n - 2 - 4 * NCH];
   endfunction

   task automatic do_reset(input logic trk, input logic rate);
      rst_n = 1'b0;
      trk_mode = trk;
      rate_sel = rate;
      out_ready = 1'b1;
      epoch_tick = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // Collect one packet; toggle stalls ready, corrupt changes inputs mid-packet.
   task automatic collect(input bit toggle, input bit corrupt);
      int n = 0, waited = 0;
      bit prev_stall = 0, ph = 0;
      logic [7:0] held = '0;
      while (n < PKT && waited < 20000) begin
         @(negedge clk);
         waited++;
         if (prev_stall)
            chk(out_valid && out_data == held, "R11", "data held under stall", int'(out_data), int'(held));
         out_ready = toggle ? ph : 1'b1;
         ph = ~ph;
         prev_stall = out_valid && !out_ready;
         held = out_data;
         if (out_valid && out_ready) begin
            if (n == 0) got_start = cyc;
            got[n] = out_data;
            if (out_last != (n == PKT - 1))
               chk(0, "R1", "last flag position", n, PKT - 1);
            n++;
            if (corrupt && n == 5) begin
               ch_i = ~ch_i; ch_q = ~ch_q; ch_time = ~ch_time; ch_valid = ~ch_valid;
            end
         end
      end
      out_ready = 1'b1;
      chk(n == PKT, "R1", "bytes in packet", n, PKT);
   endtask

   task automatic check_pkt(input logic [7:0] tag, input string req);
      int bad = -1;
      for (int n = PKT - 1; n >= 0; n--) if (got[n] !== exp_byte(n, tag)) bad = n;
      if (bad < 0) chk(1, req, "packet", 0, 0);
      else chk(0, req, $sformatf("byte %0d", bad), int'(got[bad]), int'(exp_byte(bad, tag)));
   endtask

   task automatic t_reset;
      do_reset(1'b1, 1'b0);
      chk(out_valid == 1'b0, "R1", "valid after reset", int'(out_valid), 0);
      chk(overrun == 1'b0, "R12", "overrun after reset", int'(overrun), 0);
   endtask

   task automatic t_tracking;
      int s0, c0;
      set_pattern(1, '1);
      time_now = 6'h2A;
      do_reset(1'b1, 1'b0);
      collect(0, 0);
      check_pkt(8'hAA, "R3");
      chk(got[1] == 8'hAA, "R5", "tracking tag", int'(got[1]), 8'hAA);
      chk(got[0] == SYNC, "R2", "sync byte", int'(got[0]), int'(SYNC));
      s0 = got_start;
      time_now = 6'h15;
      collect(0, 0);
      chk(got[1] == 8'h95, "R5", "tracking tag new time", int'(got[1]), 8'h95);
      chk(got_start - s0 == 840 * CPU, "R8", "tracking rate 0 interval", got_start - s0, 840 * CPU);
      @(negedge clk);
      c0 = cyc;
      rate_sel = 1'b1;
      collect(0, 0);
      chk(got_start == c0 + 1 + 970 * CPU, "R9", "restart after rate change", got_start, c0 + 1 + 970 * CPU);
      s0 = got_start;
      collect(0, 0);
      chk(got_start - s0 == 970 * CPU, "R8", "tracking rate 1 interval", got_start - s0, 970 * CPU);
   endtask

   task automatic t_acq_slow;
      int s0;
      set_pattern(2, 12'b1010_0101_1100);
      time_now = 6'h05;
      do_reset(1'b0, 1'b1);
      collect(0, 0);
      check_pkt(8'h85, "R4");
      s0 = got_start;
      for (int k = 0; k < 17; k++) begin
         collect(0, 0);
         if (k == 0) begin
            chk(got[1] == 8'h02, "R6", "first sequence tag", int'(got[1]), 2);
            chk(got_start - s0 == 62 * CPU, "R8", "acq rate 1 interval", got_start - s0, 62 * CPU);
         end
      end
      chk(got[1] == 8'h10, "R7", "saturate at 16", int'(got[1]), 16);
      time_now = 6'h09;
      @(negedge clk);
      epoch_tick = 1'b1;
      @(negedge clk);
      epoch_tick = 1'b0;
      collect(0, 0);
      chk(got[1] == 8'h89, "R6", "first tag after epoch", int'(got[1]), 8'h89);
      collect(0, 0);
      chk(got[1] == 8'h02, "R6", "sequence restarts", int'(got[1]), 2);
   endtask

   task automatic t_acq_fast;
      int s0, c0;
      set_pattern(3, '1);
      time_now = 6'h11;
      do_reset(1'b0, 1'b0);
      collect(0, 0);
      chk(got[1] == 8'h91, "R6", "first tag after reset", int'(got[1]), 8'h91);
      s0 = got_start;
      for (int k = 0; k < 32; k++) begin
         collect(0, 0);
         if (k == 0) chk(got_start - s0 == 31 * CPU, "R8", "acq rate 0 interval", got_start - s0, 31 * CPU);
         if (k == 30) chk(got[1] == 8'h20, "R7", "reach 32", int'(got[1]), 32);
      end
      chk(got[1] == 8'h20, "R7", "saturate at 32", int'(got[1]), 32);
      repeat (20) @(negedge clk);
      c0 = cyc;
      rate_sel = 1'b1;
      collect(0, 0);
      chk(got_start == c0 + 1 + 62 * CPU, "R9", "restart timing", got_start, c0 + 1 + 62 * CPU);
      chk(got[1] == 8'h91, "R9", "first tag after change", int'(got[1]), 8'h91);
   endtask

   task automatic t_snapshot_stall;
      set_pattern(4, 12'b0110_1001_0011);
      time_now = 6'h3F;
      do_reset(1'b0, 1'b0);
      collect(0, 1);
      check_pkt(8'hBF, "R10");
      set_pattern(5, '1);
      collect(1, 0);
      check_pkt(8'h02, "R11");
   endtask

   task automatic t_overrun;
      set_pattern(6, '1);
      time_now = 6'h01;
      do_reset(1'b0, 1'b0);
      out_ready = 1'b0;
      while (!out_valid) @(negedge clk);
      chk(overrun == 1'b0, "R12", "no overrun before second tick", int'(overrun), 0);
      repeat (31 * CPU + 10) @(negedge clk);
      chk(overrun == 1'b1, "R12", "overrun set", int'(overrun), 1);
      collect(0, 0);
      check_pkt(8'h81, "R12");
      repeat (5) @(negedge clk);
      chk(overrun == 1'b1, "R12", "overrun sticky", int'(overrun), 1);
   endtask

   initial begin
      t_reset();
      t_tracking();
      t_acq_slow();
      t_acq_fast();
      t_snapshot_stall();
      t_overrun();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule